// File: doc/BRIEF.md
# PLL Configuration and Lock Timer

This block is the digital control shell around a single analog PLL. A bus-side write port loads an 8-bit reference divider, a multiplier field and a lock-wait count in one beat. The block presents these settings to the analog PLL along with an enable and a reference-gate signal. It also supplies a select that halves the PLL output clock further down the clock path. The PLL runs at (multiplier + 1) / divider times its reference. A multiplier of zero powers the PLL down. A divider of zero holds the divided reference, and therefore the PLL output, at constant 0.

Lock is not sensed from the analog circuit. Each effective reprogramming counts as a change event, and a write that leaves the divider, multiplier and count as they were does not. A change event clears the lock status at once and sends a Gray-coded event count to the slow-clock domain. There a state machine reloads a down-counter with the lock-wait count and steps it once per slow-clock cycle. The states are LK_OFF, LK_COUNT and LK_LOCKED. The transitions are:

- restart: any state goes to LK_COUNT on a new event while the settings are nonzero.
- gate-off: any state goes to LK_OFF on a new event, or whenever divider or multiplier is zero.
- expire: LK_COUNT goes to LK_LOCKED when the counter is at zero.

The locked state is synchronized back to the bus clock together with the event tag at which it was reached. A sticky flag records each rising lock. The flag raises the interrupt when interrupts are enabled, and a status read clears it.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, pll_div, pll_mul, pll_en, pll_ref_on, out_half_sel, stat_lock, stat_flag and irq are all 0.
- R2: On a bus clock edge with wr_en high, pll_div, pll_mul and out_half_sel take wr_div, wr_mul and wr_half, and the interrupt enable takes wr_ie. The outputs are visible after that edge.
- R3: pll_ref_on is 1 exactly when the divider is nonzero. With the divider at 0, stat_lock never becomes 1.
- R4: pll_en is 1 exactly when the multiplier is nonzero. With the multiplier at 0, stat_lock never becomes 1.
- R5: After a change event with nonzero divider and multiplier and lock-wait count N, stat_lock is still 0 after N+2 slow-clock periods. It is 1 after N+5 slow-clock periods, with the bus clock at least 4 times faster than the slow clock.
- R6: A write that changes the divider, multiplier or lock-wait count drives stat_lock to 0 immediately after its edge, even if a previous count was still running. The count then restarts from the new value.
- R7: A write that leaves divider, multiplier and count unchanged does not clear stat_lock or restart the count, even if it changes the halving select or the interrupt enable.
- R8: stat_flag becomes 1 together with every rising edge of stat_lock and holds until a cycle with rd_stat high. It is 0 after that cycle unless a new lock rise happens in the same cycle.
- R9: irq equals stat_flag gated by the interrupt enable bit written through wr_ie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-side clock |
| rst_bus_n | input | 1 | Active-low reset, bus domain |
| clk_slow | input | 1 | Slow clock that times the lock wait |
| rst_slow_n | input | 1 | Active-low reset, slow domain |
| wr_en | input | 1 | Configuration write strobe |
| wr_div | input | DIV_W | Reference divider value, 0 gates the reference off |
| wr_mul | input | MUL_W | Multiplier value, 0 disables the PLL |
| wr_cnt | input | CNT_W | Lock-wait count in slow-clock cycles |
| wr_half | input | 1 | Select halving of the PLL output clock |
| wr_ie | input | 1 | Lock interrupt enable |
| rd_stat | input | 1 | Status read strobe, clears the lock flag |
| pll_div | output | DIV_W | Divider setting to the analog PLL |
| pll_mul | output | MUL_W | Multiplier setting to the analog PLL |
| pll_en | output | 1 | PLL power enable |
| pll_ref_on | output | 1 | Divided reference running |
| out_half_sel | output | 1 | Divide-by-two select on the PLL output path |
| stat_lock | output | 1 | Lock status |
| stat_flag | output | 1 | Sticky lock-event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit divider, an 11-bit multiplier, a 6-bit count and a 4-bit event tag. The slow clock is ten times slower than the bus clock. These defaults let the table reach the extreme settings 255 and 2047, a zero count and counts long enough to restart mid-wait. The lock window of R5 is then measured in whole slow periods that cover every synchronizer phase.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [1:0] {
        LK_OFF    = 2'd0,
        LK_COUNT  = 2'd1,
        LK_LOCKED = 2'd2
    } lk_state_e;

    function automatic logic [15:0] bin2gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/plc_sync.sv
module plc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/plc_bus_regs.sv
module plc_bus_regs #(
    parameter int DIV_W = 8,
    parameter int MUL_W = 11,
    parameter int CNT_W = 6,
    parameter int EV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [MUL_W-1:0] wr_mul,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_half,
    input  logic             wr_ie,
    input  logic             rd_stat,
    input  logic             lock_s,
    input  logic [EV_W-1:0]  tag_s,
    output logic [DIV_W-1:0] cfg_div,
    output logic [MUL_W-1:0] cfg_mul,
    output logic [CNT_W-1:0] cfg_cnt,
    output logic             cfg_half,
    output logic [EV_W-1:0]  ev_gray,
    output logic             stat_lock,
    output logic             stat_flag,
    output logic             irq
);
    import plc_pkg::*;

    logic            cfg_ie;
    logic [EV_W-1:0] ev_bin;
    logic [EV_W-1:0] ev_bin_nxt;
    logic            chg;
    logic            lock_nxt;

    assign chg = wr_en && ((wr_div != cfg_div) || (wr_mul != cfg_mul) ||
                           (wr_cnt != cfg_cnt));
    assign ev_bin_nxt = chg ? ev_bin + 1'b1 : ev_bin;

    // Lock is believed only when the slow side reached it for the newest event.
    assign lock_nxt = !chg && lock_s && (tag_s == ev_gray) &&
                      (cfg_div != '0) && (cfg_mul != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_div  <= '0;
            cfg_mul  <= '0;
            cfg_cnt  <= '0;
            cfg_half <= 1'b0;
            cfg_ie   <= 1'b0;
        end else if (wr_en) begin
            cfg_div  <= wr_div;
            cfg_mul  <= wr_mul;
            cfg_cnt  <= wr_cnt;
            cfg_half <= wr_half;
            cfg_ie   <= wr_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_bin  <= '0;
            ev_gray <= '0;
        end else begin
            ev_bin  <= ev_bin_nxt;
            ev_gray <= EV_W'(bin2gray(16'(ev_bin_nxt)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_lock <= 1'b0;
            stat_flag <= 1'b0;
        end else begin
            stat_lock <= lock_nxt;
            if (lock_nxt && !stat_lock)
                stat_flag <= 1'b1;
            else if (rd_stat)
                stat_flag <= 1'b0;
        end
    end

    assign irq = stat_flag && cfg_ie;
endmodule

// File: rtl/plc_lock_fsm.sv
module plc_lock_fsm #(
    parameter int CNT_W = 6,
    parameter int EV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  ev_s,
    input  logic             cfg_off,
    input  logic [CNT_W-1:0] cfg_cnt,
    output logic             lock,
    output logic [EV_W-1:0]  tag
);
    import plc_pkg::*;

    lk_state_e        state, nxt;
    logic [EV_W-1:0]  seen;
    logic [CNT_W-1:0] ctr;
    logic             detect;

    assign detect = (ev_s != seen);

    always_comb begin
        nxt = state;
        if (detect) begin
            nxt = cfg_off ? LK_OFF : LK_COUNT;
        end else begin
            unique case (state)
                LK_OFF:    nxt = LK_OFF;
                LK_COUNT:  nxt = cfg_off ? LK_OFF :
                                 (ctr == '0) ? LK_LOCKED : LK_COUNT;
                LK_LOCKED: nxt = cfg_off ? LK_OFF : LK_LOCKED;
                default:   nxt = LK_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
            ctr  <= '0;
            lock <= 1'b0;
            tag  <= '0;
        end else begin
            if (detect) begin
                seen <= ev_s;
                ctr  <= cfg_cnt;
            end else if (state == LK_COUNT && ctr != '0) begin
                ctr <= ctr - 1'b1;
            end
            lock <= (nxt == LK_LOCKED);
            if (nxt == LK_LOCKED && state != LK_LOCKED)
                tag <= seen;
        end
    end
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl #(
    parameter int DIV_W = 8,
    parameter int MUL_W = 11,
    parameter int CNT_W = 6,
    parameter int EV_W  = 4
) (
    input  logic             clk_bus,
    input  logic             rst_bus_n,
    input  logic             clk_slow,
    input  logic             rst_slow_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [MUL_W-1:0] wr_mul,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_half,
    input  logic             wr_ie,
    input  logic             rd_stat,
    output logic [DIV_W-1:0] pll_div,
    output logic [MUL_W-1:0] pll_mul,
    output logic             pll_en,
    output logic             pll_ref_on,
    output logic             out_half_sel,
    output logic             stat_lock,
    output logic             stat_flag,
    output logic             irq
);
    logic [CNT_W-1:0] cfg_cnt;
    logic [EV_W-1:0]  ev_gray, ev_s, tag, tag_s;
    logic             lock, lock_s;
    logic             cfg_off;

    plc_bus_regs #(.DIV_W(DIV_W), .MUL_W(MUL_W), .CNT_W(CNT_W), .EV_W(EV_W)) u_regs (
        .clk(clk_bus), .rst_n(rst_bus_n),
        .wr_en(wr_en), .wr_div(wr_div), .wr_mul(wr_mul), .wr_cnt(wr_cnt),
        .wr_half(wr_half), .wr_ie(wr_ie), .rd_stat(rd_stat),
        .lock_s(lock_s), .tag_s(tag_s),
        .cfg_div(pll_div), .cfg_mul(pll_mul), .cfg_cnt(cfg_cnt),
        .cfg_half(out_half_sel), .ev_gray(ev_gray),
        .stat_lock(stat_lock), .stat_flag(stat_flag), .irq(irq)
    );

    // Settings are quasi-static: the event reaches the slow side two flops later.
    assign cfg_off    = (pll_div == '0) || (pll_mul == '0);
    assign pll_en     = (pll_mul != '0);
    assign pll_ref_on = (pll_div != '0);

    plc_sync #(.W(EV_W)) u_ev_sync (
        .clk(clk_slow), .rst_n(rst_slow_n), .d(ev_gray), .q(ev_s)
    );

    plc_lock_fsm #(.CNT_W(CNT_W), .EV_W(EV_W)) u_fsm (
        .clk(clk_slow), .rst_n(rst_slow_n), .ev_s(ev_s), .cfg_off(cfg_off),
        .cfg_cnt(cfg_cnt), .lock(lock), .tag(tag)
    );

    plc_sync #(.W(EV_W + 1)) u_lock_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d({lock, tag}), .q({lock_s, tag_s})
    );
endmodule

// File: rtl/plc_chk.sv
module plc_chk #(
    parameter int DIV_W = 8,
    parameter int MUL_W = 11,
    parameter int CNT_W = 6
) (
    input logic             clk_bus,
    input logic             rst_bus_n,
    input logic             wr_en,
    input logic [DIV_W-1:0] wr_div,
    input logic [MUL_W-1:0] wr_mul,
    input logic [CNT_W-1:0] wr_cnt,
    input logic             rd_stat,
    input logic [DIV_W-1:0] pll_div,
    input logic [MUL_W-1:0] pll_mul,
    input logic [CNT_W-1:0] cfg_cnt,
    input logic             pll_en,
    input logic             pll_ref_on,
    input logic             stat_lock,
    input logic             stat_flag,
    input logic             irq
);
    logic same_wr;
    assign same_wr = wr_en && (wr_div == pll_div) && (wr_mul == pll_mul) &&
                     (wr_cnt == cfg_cnt);

    p_cfg_load_r2: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        wr_en |=> (pll_div == $past(wr_div)) && (pll_mul == $past(wr_mul)));

    p_gate_r3: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        stat_lock |-> pll_ref_on);

    p_gate_r4: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        stat_lock |-> pll_en);

    p_clear_r6: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_en && !same_wr) |=> !stat_lock);

    p_keep_r7: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (same_wr && stat_lock) |=> stat_lock);

    p_flag_rise_r8: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        $rose(stat_lock) |-> stat_flag);

    p_flag_hold_r8: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (stat_flag && !rd_stat) |=> stat_flag);

    p_flag_clr_r8: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        rd_stat |=> (!stat_flag || $rose(stat_lock)));

    p_irq_r9: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        irq |-> stat_flag);
endmodule

bind pll_lock_ctrl plc_chk #(.DIV_W(DIV_W), .MUL_W(MUL_W), .CNT_W(CNT_W)) u_chk (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .wr_div(wr_div),
    .wr_mul(wr_mul), .wr_cnt(wr_cnt), .rd_stat(rd_stat), .pll_div(pll_div),
    .pll_mul(pll_mul), .cfg_cnt(cfg_cnt), .pll_en(pll_en), .pll_ref_on(pll_ref_on),
    .stat_lock(stat_lock), .stat_flag(stat_flag), .irq(irq)
);

// File: tb/pll_lock_ctrl_tb_top.sv
module pll_lock_ctrl_tb_top;
    localparam int DIV_W = 8;
    localparam int MUL_W = 11;
    localparam int CNT_W = 6;
    localparam int BUS_HALF  = 2;
    localparam int SLOW_HALF = 20;
    localparam int RATIO = SLOW_HALF / BUS_HALF;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [MUL_W-1:0] mul;
        logic [CNT_W-1:0] cnt;
        logic             half;
        logic             ie;
        logic             exp_lock;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{div: 8'd1,   mul: 11'd1,    cnt: 6'd0,  half: 1'b0, ie: 1'b1, exp_lock: 1'b1},
        '{div: 8'd5,   mul: 11'd20,   cnt: 6'd7,  half: 1'b1, ie: 1'b0, exp_lock: 1'b1},
        '{div: 8'd0,   mul: 11'd20,   cnt: 6'd7,  half: 1'b0, ie: 1'b1, exp_lock: 1'b0},
        '{div: 8'd3,   mul: 11'd0,    cnt: 6'd4,  half: 1'b0, ie: 1'b1, exp_lock: 1'b0},
        '{div: 8'd255, mul: 11'd2047, cnt: 6'd12, half: 1'b1, ie: 1'b1, exp_lock: 1'b1},
        '{div: 8'd8,   mul: 11'd3,    cnt: 6'd20, half: 1'b0, ie: 1'b1, exp_lock: 1'b1}
    };

    logic clk_bus = 1'b0, clk_slow = 1'b0;
    logic rst_bus_n = 1'b0, rst_slow_n = 1'b0;
    logic wr_en = 1'b0, wr_half = 1'b0, wr_ie = 1'b0, rd_stat = 1'b0;
    logic [DIV_W-1:0] wr_div = '0;
    logic [MUL_W-1:0] wr_mul = '0;
    logic [CNT_W-1:0] wr_cnt = '0;
    logic [DIV_W-1:0] pll_div;
    logic [MUL_W-1:0] pll_mul;
    logic pll_en, pll_ref_on, out_half_sel, stat_lock, stat_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #BUS_HALF  clk_bus  = ~clk_bus;
    always #SLOW_HALF clk_slow = ~clk_slow;

    pll_lock_ctrl #(.DIV_W(DIV_W), .MUL_W(MUL_W), .CNT_W(CNT_W)) dut_i (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_slow(clk_slow),
        .rst_slow_n(rst_slow_n), .wr_en(wr_en), .wr_div(wr_div), .wr_mul(wr_mul),
        .wr_cnt(wr_cnt), .wr_half(wr_half), .wr_ie(wr_ie), .rd_stat(rd_stat),
        .pll_div(pll_div), .pll_mul(pll_mul), .pll_en(pll_en),
        .pll_ref_on(pll_ref_on), .out_half_sel(out_half_sel),
        .stat_lock(stat_lock), .stat_flag(stat_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [DIV_W-1:0] d, input logic [MUL_W-1:0] m,
                      input logic [CNT_W-1:0] c, input logic h, input logic ie);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_div = d; wr_mul = m; wr_cnt = c; wr_half = h; wr_ie = ie;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk_bus);
        rd_stat = 1'b1;
        @(negedge clk_bus);
        rd_stat = 1'b0;
    endtask

    task automatic wait_slow(input int n);
        repeat (n * RATIO) @(negedge clk_bus);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_slow);
        rst_slow_n = 1'b1;
        @(negedge clk_bus);
        rst_bus_n = 1'b1;
        @(negedge clk_bus);
        // R1 reset state
        check("R1 pll_div", int'(pll_div), 0);
        check("R1 pll_mul", int'(pll_mul), 0);
        check("R1 pll_en", int'(pll_en), 0);
        check("R1 pll_ref_on", int'(pll_ref_on), 0);
        check("R1 out_half_sel", int'(out_half_sel), 0);
        check("R1 stat_lock", int'(stat_lock), 0);
        check("R1 stat_flag", int'(stat_flag), 0);
        check("R1 irq", int'(irq), 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            wr(v.div, v.mul, v.cnt, v.half, v.ie);
            check("R2 pll_div", int'(pll_div), int'(v.div));
            check("R2 pll_mul", int'(pll_mul), int'(v.mul));
            check("R2 out_half_sel", int'(out_half_sel), int'(v.half));
            check("R3 pll_ref_on", int'(pll_ref_on), int'(v.div != 0));
            check("R4 pll_en", int'(pll_en), int'(v.mul != 0));
            check("R6 lock cleared by change", int'(stat_lock), 0);
            wait_slow(int'(v.cnt) + 2);
            check("R5 lock not early", int'(stat_lock), 0);
            wait_slow(3);
            check(v.exp_lock ? "R5 lock in window" : "R3 R4 lock gated",
                  int'(stat_lock), int'(v.exp_lock));
            check("R8 flag on lock", int'(stat_flag), int'(v.exp_lock));
            check("R9 irq gated", int'(irq), int'(v.exp_lock && v.ie));
            read_stat();
            check("R8 flag cleared by read", int'(stat_flag), 0);
            check("R9 irq after read", int'(irq), 0);
        end

        // R7: same settings, other bits flipped; lock must survive
        wr(8'd8, 11'd3, 6'd20, 1'b1, 1'b0);
        check("R7 lock kept", int'(stat_lock), 1);
        check("R2 half updated", int'(out_half_sel), 1);
        wait_slow(8);
        check("R7 lock still kept", int'(stat_lock), 1);
        check("R7 no new flag", int'(stat_flag), 0);

        // R6: restart in the middle of a running count
        wr(8'd4, 11'd6, 6'd30, 1'b0, 1'b1);
        check("R6 lock cleared", int'(stat_lock), 0);
        wait_slow(10);
        wr(8'd4, 11'd6, 6'd3, 1'b0, 1'b1);
        wait_slow(5);
        check("R6 restart not early", int'(stat_lock), 0);
        wait_slow(3);
        check("R6 restart locks with new count", int'(stat_lock), 1);
        // R8: flag holds without a read
        repeat (7) @(negedge clk_bus);
        check("R8 flag held", int'(stat_flag), 1);
        check("R9 irq with enable", int'(irq), 1);
        read_stat();
        check("R8 flag cleared", int'(stat_flag), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule